// File: doc/BRIEF.md
# Supervisory Reset Sequencer

This block turns digitized supply-status flags and a raw push-button line into a clean system reset. A flag saying the main supply has dropped below its primary threshold forces reset immediately. The same happens after a debounced manual press. Every cause is then followed by a hold-off interval before reset lets go. Power-up counts as a cause too: it begins when the block's own reset input is released.

All causes share one stretch timer. A two-bit code picks one of four durations in the ratio 1:4:8:16. Durations are counted in prescaled ticks, so a tiny prescale can drive them in simulation and a real one in silicon.

Two status outputs bypass the timer completely. An early low-line warning mirrors the primary supply flag. A secondary-supply good flag mirrors the second monitor.

Top module: `rst_supervisor`

## Requirements
- R1: While `vcc_low_i` is 1, the reset output is asserted in the same cycle, combinationally, and stays asserted for as long as the flag is 1.
- R2: Once every cause has cleared, reset stays asserted for the selected duration and then releases. Every cause restarts the duration, including the release of `rst_n`, which acts as power-up.
- R3: `tmo_sel_i` codes 0, 1, 2 and 3 select DUR_UNIT×1, ×4, ×8 and ×16 ticks. One tick is TICK_DIV clock cycles. The measured hold-off lies between (D−1)×TICK_DIV and D×TICK_DIV+2 cycles, where D is the selected tick count.
- R4: A debounced low level on `mr_raw_n_i` asserts reset. Reset stays asserted while the pin is held low, and for the debounce delay plus one full duration after the pin is released.
- R5: The manual input passes a two-flop synchronizer. A new level is accepted only after it has been stable for DB_TICKS consecutive ticks. A low pulse shorter than that never asserts reset.
- R6: `lowline_n_o` equals the inverse of `vcc_low_i` with no delay and no stretch.
- R7: `v2_ok_o` equals the inverse of `v2_low_i` with no delay, during reset and outside it.
- R8: When `pol_high_i` is 1, `sys_rst_o` is high while reset is asserted. When it is 0, `sys_rst_o` is low while reset is asserted. The timing is the same in both cases.
- R9: A cause that arrives while the timer is running discards the partial count. The full duration then runs again from zero once all causes have cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset; its release acts as power-up |
| vcc_low_i | input | 1 | 1 = main supply below primary threshold |
| v2_low_i | input | 1 | 1 = secondary monitor below its threshold |
| mr_raw_n_i | input | 1 | Raw manual reset, active low, asynchronous |
| tmo_sel_i | input | 2 | Hold-off duration select |
| pol_high_i | input | 1 | 1 = active-high reset output, 0 = active-low |
| sys_rst_o | output | 1 | System reset in the selected polarity |
| lowline_n_o | output | 1 | Early warning, low while the main supply is below threshold |
| v2_ok_o | output | 1 | High while the secondary supply is above threshold |

## Verification
A wrong stretch count shows up at the reset pin as a release that comes early or late. A code mapped to the wrong duration lands outside its window in the duration sweep within about a hundred cycles. A debounce counter that never clears lets a short manual glitch through, and reset then asserts within a few ticks. A timer that fails to restart on a fresh cause releases too soon after a second dip.

// File: rtl/rst_sup_pkg.sv
package rst_sup_pkg;

    typedef struct packed {
        logic sync1;
        logic sync2;
        logic filt;
        logic [7:0] cnt;
    } db_state_t;

    function automatic int unsigned dur_ticks(input logic [1:0] sel, input int unsigned unit);
        case (sel)
            2'd0:    return unit;
            2'd1:    return unit * 4;
            2'd2:    return unit * 8;
            default: return unit * 16;
        endcase
    endfunction

endpackage

// File: rtl/rst_tick_gen.sv
module rst_tick_gen #(
    parameter int unsigned TICK_DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int unsigned TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    generate
        if (TICK_DIV <= 1) begin : g_every
            assign tick_o = 1'b1;
        end else begin : g_div
            logic [TW-1:0] cnt_d, cnt_q;
            always_comb begin
                if (cnt_q == TW'(TICK_DIV - 1)) cnt_d = '0;
                else                            cnt_d = cnt_q + 1'b1;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end
            assign tick_o = (cnt_q == TW'(TICK_DIV - 1));

            AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o); // R3
        end
    endgenerate
endmodule

// File: rtl/rst_debounce.sv
module rst_debounce
    import rst_sup_pkg::*;
#(
    parameter int unsigned DB_TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic raw_n_i,
    output logic filt_n_o
);
    db_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.sync1 = raw_n_i;
        st_d.sync2 = st_q.sync1;
        if (st_q.sync2 == st_q.filt) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            if (st_q.cnt >= 8'(DB_TICKS - 1)) begin
                st_d.filt = st_q.sync2;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 8'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{sync1: 1'b1, sync2: 1'b1, filt: 1'b1, cnt: 8'd0};
        else        st_q <= st_d;
    end

    assign filt_n_o = st_q.filt;

    initial begin
        assert (DB_TICKS >= 1 && DB_TICKS <= 255);
    end

    AST_FILT_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(st_q.filt)); // R5
    AST_FILT_NEEDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sync2 == st_q.filt) |=> $stable(st_q.filt)); // R5
endmodule

// File: rtl/rst_stretch.sv
module rst_stretch
    import rst_sup_pkg::*;
#(
    parameter int unsigned DUR_UNIT = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       cause_i,
    input  logic [1:0] sel_i,
    output logic       busy_o
);
    localparam int unsigned MAXD = DUR_UNIT * 16;
    localparam int unsigned CW   = $clog2(MAXD + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [31:0] need;

    always_comb begin
        need = 32'(dur_ticks(sel_i, DUR_UNIT));
        st_d = st_q;
        if (cause_i) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
        end else if (st_q.busy && tick_i) begin
            if (32'(st_q.cnt) + 32'd1 >= need) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{busy: 1'b1, cnt: '0};
        else        st_q <= st_d;
    end

    assign busy_o = st_q.busy;

    AST_CAUSE_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cause_i |=> busy_o); // R1
    AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.busy |-> (st_q.cnt == '0)); // R2
    AST_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.busy) |-> ($past(tick_i) && !$past(cause_i))); // R2
    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cause_i |=> (st_q.cnt == '0)); // R9
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
    parameter int unsigned TICK_DIV = 1000,
    parameter int unsigned DUR_UNIT = 50,
    parameter int unsigned DB_TICKS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vcc_low_i,
    input  logic       v2_low_i,
    input  logic       mr_raw_n_i,
    input  logic [1:0] tmo_sel_i,
    input  logic       pol_high_i,
    output logic       sys_rst_o,
    output logic       lowline_n_o,
    output logic       v2_ok_o
);
    logic tick;
    logic mr_filt_n;
    logic cause;
    logic busy;
    logic active;

    rst_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    rst_debounce #(.DB_TICKS(DB_TICKS)) u_db (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .raw_n_i  (mr_raw_n_i),
        .filt_n_o (mr_filt_n)
    );

    assign cause = vcc_low_i | ~mr_filt_n;

    rst_stretch #(.DUR_UNIT(DUR_UNIT)) u_str (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .cause_i (cause),
        .sel_i   (tmo_sel_i),
        .busy_o  (busy)
    );

    assign active      = busy | vcc_low_i;
    assign sys_rst_o   = pol_high_i ? active : ~active;
    assign lowline_n_o = ~vcc_low_i;
    assign v2_ok_o     = ~v2_low_i;

    AST_LOWLINE_IMPLIES_RST: assert property (@(posedge clk) disable iff (!rst_n)
        !lowline_n_o |-> (sys_rst_o == pol_high_i)); // R1
    AST_MR_HELD_RST: assert property (@(posedge clk) disable iff (!rst_n)
        !mr_filt_n |=> (sys_rst_o == pol_high_i)); // R4
endmodule

// File: tb/rst_supervisor_test.sv
module rst_supervisor_test;
    localparam int TD = 2;
    localparam int UNIT = 3;
    localparam int DB = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vcc_low = 1'b0, v2_low = 1'b0, mr_n = 1'b1, pol = 1'b1;
    logic [1:0] sel = 2'd0;
    logic sys_rst, lowline_n, v2_ok;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    rst_supervisor #(.TICK_DIV(TD), .DUR_UNIT(UNIT), .DB_TICKS(DB)) uut (
        .clk(clk), .rst_n(rst_n), .vcc_low_i(vcc_low), .v2_low_i(v2_low),
        .mr_raw_n_i(mr_n), .tmo_sel_i(sel), .pol_high_i(pol),
        .sys_rst_o(sys_rst), .lowline_n_o(lowline_n), .v2_ok_o(v2_ok));

    function automatic int dur(input int s);
        return UNIT * ((s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 16);
    endfunction

    function automatic logic act();
        return pol ? sys_rst : ~sys_rst;
    endfunction

    task automatic chk(input logic ok, input string req, input int act_v, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act_v, exp_v);
        end
    endtask

    task automatic measure(output int n);
        n = 0;
        while (act() && n < 2000) begin
            @(posedge clk); #1;
            n++;
        end
    endtask

    task automatic chk_window(input int n, input int lo, input int hi, input string req);
        chk(n >= lo && n <= hi, req, n, lo);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk(sys_rst == 1'b1, "R2 reset state", sys_rst, 1);
        chk(lowline_n == 1'b1 && v2_ok == 1'b1, "R6 R7 reset state", lowline_n, 1);
        @(negedge clk); rst_n = 1'b1; #1;
        measure(n);
        chk_window(n, (dur(0) - 1) * TD, dur(0) * TD + 2, "R2 power-up");

        // Sweep all duration codes in both polarities.
        for (int p = 0; p < 2; p++) begin
            for (int s = 0; s < 4; s++) begin
                @(negedge clk);
                pol = p[0]; sel = s[1:0]; #1;
                chk(act() == 1'b0, "R8 idle level", sys_rst, p == 0 ? 1 : 0);
                vcc_low = 1'b1; #1;
                chk(act() == 1'b1, "R1 immediate", sys_rst, p);
                chk(lowline_n == 1'b0, "R6 low", lowline_n, 0);
                repeat (5) @(negedge clk);
                chk(sys_rst == p[0], "R8 polarity held", sys_rst, p);
                vcc_low = 1'b0; #1;
                chk(lowline_n == 1'b1, "R6 high", lowline_n, 1);
                measure(n);
                chk_window(n, (dur(s) - 1) * TD, dur(s) * TD + 2, "R3 duration");
            end
        end
        pol = 1'b1; sel = 2'd0;

        // Secondary flag, in and out of reset.
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            vcc_low = k[1]; v2_low = k[0]; #1;
            chk(v2_ok == ~k[0], "R7 follow", v2_ok, !k[0]);
        end
        @(negedge clk); vcc_low = 1'b0; v2_low = 1'b0; #1;
        measure(n);

        // Short manual glitch ignored.
        @(negedge clk); mr_n = 1'b0;
        repeat ((DB - 2) * TD) @(negedge clk);
        mr_n = 1'b1;
        begin
            int seen = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (act()) seen++;
            end
            chk(seen == 0, "R5 glitch ignored", seen, 0);
        end

        // Held manual press.
        @(negedge clk); mr_n = 1'b0;
        repeat (40) @(negedge clk);
        chk(act() == 1'b1, "R4 held asserts", sys_rst, 1);
        mr_n = 1'b1; #1;
        measure(n);
        chk_window(n, (DB - 1) * TD + (dur(0) - 1) * TD, DB * TD + dur(0) * TD + 4, "R4 release");

        // Restart during timeout.
        sel = 2'd3;
        @(negedge clk); vcc_low = 1'b1;
        repeat (2) @(negedge clk);
        vcc_low = 1'b0;
        repeat (40) @(negedge clk);
        chk(act() == 1'b1, "R9 mid timeout", sys_rst, 1);
        vcc_low = 1'b1;
        repeat (2) @(negedge clk);
        vcc_low = 1'b0; #1;
        measure(n);
        chk_window(n, (dur(3) - 1) * TD, dur(3) * TD + 2, "R9 full restart");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule